// File: doc/BRIEF.md
# Dual-Mode Processor Counter / User Timer Bank

This block holds one timer per processor, and each timer has two personalities. In counter mode a timer is an interrupting limit counter. It counts ticks up to a programmed limit, wraps to zero, sets a reached flag and raises its interrupt line. A zero limit makes it run free. In user mode the same counting register becomes a 54-bit gated up-counter, measured in ticks. Software reads it as two 32-bit words in which the nine lowest bits of the combined value always read as zero. Software can start and stop it, and it never interrupts. A shared mode mask, with one bit per processor, picks the personality. Each processor has its own word-addressed register port. The tick pulse comes from a prescaler outside the block.

Each timer runs a small state machine with three states. `ST_COUNTER` is the limit-counter personality. `ST_USER_RUN` is user mode with counting enabled. `ST_USER_HALT` is user mode with counting held. The transitions are as follows:
- "enter-user" goes from `ST_COUNTER` to `ST_USER_RUN` or `ST_USER_HALT`, following the stored run bit. It fires when the mask bit rises.
- "leave-user" goes from either user state to `ST_COUNTER`. It fires when the mask bit falls.
- "start" goes from `ST_USER_HALT` to `ST_USER_RUN`, on a write of 1 to the run word.
- "stop" goes from `ST_USER_RUN` to `ST_USER_HALT`, on a write of 0 to the run word.

Top module: `dual_mode_cpu_timer`

## Requirements
- R1: After reset the mode mask is zero and every timer is in counter mode. Each timer has its run bit at 1, a count of 0, a limit of 0 (free-run), the reached flag clear and its interrupt low.
- R2: A mode write loads the whole mask, where bit i selects user mode for processor i. The mask reads back on `mode_rdata` from the next cycle. A processor whose bit does not change sees no side effect at all.
- R3: In counter mode a timer advances once per tick on a 22-bit count. With a non-zero limit L, the tick that would bring the count to L instead returns it to 0, sets the reached flag and raises the interrupt on the next cycle. With L = 0 the count wraps at 2^22 and never sets the flag. The interrupt only rises after a tick.
- R4: In counter mode, word 0 reads {0, limit[21:0], 9'b0}, and a read strobe on word 0 clears both the reached flag and the interrupt. Word 1 reads {reached, count[21:0], 9'b0}.
- R5: In counter mode, writing word 0 loads the limit from bits [30:9], restarts the count at 0 and lowers the interrupt. Writing word 2 loads the limit from the same bits and keeps the count.
- R6: In user mode, word 0 reads {reached, count[53:23]} and word 1 reads {count[22:0], 9'b0}. Reads in user mode have no side effect.
- R7: In user mode, writing word 0 loads count[53:23] from bits [30:0] and writing word 1 loads count[22:0] from bits [31:9]. Each write keeps the other half and clears the reached flag.
- R8: Bit 0 of word 3 is the run bit and reads back as written. In user mode a 0 holds the count and a 1 lets it advance on each tick. In counter mode the stored bit does not stop counting.
- R9: A user-mode timer never raises its interrupt. When its count would reach 2^54-1 it returns to 0 and sets the reached flag.
- R10: When a mask bit rises, the timer's interrupt is cleared in the same cycle. The timer then uses the fixed maximum limit. If its run bit is 0 it stays halted.
- R11: When a mask bit falls, the run bit is forced to 1. The count keeps only its low 22 bits. The counter-mode limit is the value it held before.
- R12: Processor-port accesses and ticks in the same cycle are resolved by priority. In a cycle where a processor's mode changes, its register access and its tick are dropped. A register write beats a tick. A reached event from a tick beats a clearing read in the same cycle.
- R13: A word 1 write in counter mode and a word 2 write in user mode leave the timer unchanged. Word 2 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle count pulse from the external prescaler |
| mode_wr | input | 1 | Mode mask write strobe |
| mode_wdata | input | NPROC | New mode mask, bit i selects user mode for processor i |
| mode_rdata | output | NPROC | Current mode mask |
| cpu_wr_en | input | NPROC | Per-processor register write strobe |
| cpu_rd_en | input | NPROC | Per-processor read strobe (for read side effects) |
| cpu_addr | input | 2*NPROC | Per-processor word index, 2 bits per processor |
| cpu_wdata | input | 32*NPROC | Per-processor write data, 32 bits per processor |
| cpu_rdata | output | 32*NPROC | Per-processor read data, combinational on the word index |
| irq | output | NPROC | Per-processor interrupt line |

## Verification
The bench builds the block with four processors. This lets one mask write move some timers between personalities while leaving another untouched, so the no-side-effect case of R2 can be seen next to real switches. The 54-bit user counter would be out of reach by ticking alone. Both halves are loaded just below the maximum, so the user-mode wrap and reached flag appear after two ticks. Same-cycle collisions of a mode change, a write, a tick and a clearing read are driven on purpose to pin down the priorities.

// File: rtl/dmt_pkg.sv
package dmt_pkg;

    // register word geometry
    localparam int WORD_W = 32;
    localparam int FRAC_W = 9;                    // low bits that always read zero
    localparam int LO_W   = WORD_W - FRAC_W;      // count bits held in the low word
    localparam int HI_W   = WORD_W - 1;           // count bits held in the high word
    localparam int USER_W = LO_W + HI_W;          // user-mode count width in ticks
    localparam int CNTR_W = WORD_W - 1 - FRAC_W;  // counter-mode count and limit width
    localparam int ADDR_W = 2;

    // word indices
    localparam logic [ADDR_W-1:0] W_HIGH       = 2'd0;
    localparam logic [ADDR_W-1:0] W_LOW        = 2'd1;
    localparam logic [ADDR_W-1:0] W_LIMIT_KEEP = 2'd2;
    localparam logic [ADDR_W-1:0] W_RUN        = 2'd3;

    typedef enum logic [1:0] {
        ST_COUNTER   = 2'd0,
        ST_USER_RUN  = 2'd1,
        ST_USER_HALT = 2'd2
    } tmr_state_e;

endpackage

// File: rtl/dmt_count_step.sv
module dmt_count_step
    import dmt_pkg::*;
(
    input  logic              user_mode,
    input  logic [USER_W-1:0] cnt,
    input  logic [CNTR_W-1:0] lim,
    output logic [USER_W-1:0] cnt_nxt,
    output logic              hit
);

    logic [USER_W-1:0] inc_user;
    logic [CNTR_W-1:0] inc_cntr;

    assign inc_user = cnt + USER_W'(1);
    assign inc_cntr = cnt[CNTR_W-1:0] + CNTR_W'(1);

    always_comb begin
        if (user_mode) begin
            // fixed maximum: the all-ones value is never held, it wraps to zero
            hit     = &inc_user;
            cnt_nxt = hit ? '0 : inc_user;
        end else begin
            hit     = (lim != '0) && (inc_cntr == lim);
            cnt_nxt = hit ? '0 : USER_W'(inc_cntr);
        end
    end

endmodule

// File: rtl/dmt_mode_bank.sv
module dmt_mode_bank #(
    parameter int NPROC = 4
) (
    input  logic             mode_wr,
    input  logic [NPROC-1:0] mode_wdata,
    input  logic [NPROC-1:0] is_user,
    output logic [NPROC-1:0] go_user,
    output logic [NPROC-1:0] go_counter,
    output logic [NPROC-1:0] mode_rdata
);

    for (genvar gi = 0; gi < NPROC; gi++) begin : g_bit
        // only a real change of a bit produces a switch pulse
        assign go_user[gi]    = mode_wr &  mode_wdata[gi] & ~is_user[gi];
        assign go_counter[gi] = mode_wr & ~mode_wdata[gi] &  is_user[gi];
    end

    assign mode_rdata = is_user;

endmodule

// File: rtl/dmt_timer_core.sv
module dmt_timer_core
    import dmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              go_user,
    input  logic              go_counter,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              irq,
    output logic              user_mode,
    output logic              run
);

    tmr_state_e state_q, state_d;

    logic [USER_W-1:0] cnt_q;
    logic [CNTR_W-1:0] lim_q;
    logic              reach_q;
    logic              irq_q;
    logic              run_q;

    logic              switching;
    logic              wr_act;
    logic              rd_act;
    logic              in_user;
    logic              counting;
    logic [USER_W-1:0] cnt_nxt;
    logic              hit;

    assign in_user   = (state_q != ST_COUNTER);
    assign switching = go_user | go_counter;
    assign wr_act    = wr_en & ~switching;
    assign rd_act    = rd_en & ~wr_en & ~switching;
    assign counting  = tick & ~switching & ~wr_act & (state_q != ST_USER_HALT);

    dmt_count_step u_step (
        .user_mode (in_user),
        .cnt       (cnt_q),
        .lim       (lim_q),
        .cnt_nxt   (cnt_nxt),
        .hit       (hit)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_COUNTER;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COUNTER: begin
                if (go_user) state_d = run_q ? ST_USER_RUN : ST_USER_HALT;
            end
            ST_USER_RUN: begin
                if (go_counter)                                  state_d = ST_COUNTER;
                else if (wr_act && addr == W_RUN && !wdata[0])   state_d = ST_USER_HALT;
            end
            ST_USER_HALT: begin
                if (go_counter)                                  state_d = ST_COUNTER;
                else if (wr_act && addr == W_RUN && wdata[0])    state_d = ST_USER_RUN;
            end
            default: state_d = ST_COUNTER;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            lim_q   <= '0;
            reach_q <= 1'b0;
            irq_q   <= 1'b0;
            run_q   <= 1'b1;
        end else if (go_user) begin
            irq_q <= 1'b0;
        end else if (go_counter) begin
            run_q <= 1'b1;
            cnt_q <= USER_W'(cnt_q[CNTR_W-1:0]);
        end else if (wr_act) begin
            unique case (addr)
                W_HIGH: begin
                    if (in_user) begin
                        cnt_q[USER_W-1:LO_W] <= wdata[HI_W-1:0];
                        reach_q              <= 1'b0;
                    end else begin
                        lim_q <= wdata[WORD_W-2:FRAC_W];
                        cnt_q <= '0;
                        irq_q <= 1'b0;
                    end
                end
                W_LOW: begin
                    if (in_user) begin
                        cnt_q[LO_W-1:0] <= wdata[WORD_W-1:FRAC_W];
                        reach_q         <= 1'b0;
                    end
                end
                W_LIMIT_KEEP: begin
                    if (!in_user) lim_q <= wdata[WORD_W-2:FRAC_W];
                end
                W_RUN: run_q <= wdata[0];
                default: ;
            endcase
        end else begin
            if (counting) cnt_q <= cnt_nxt;
            if (rd_act && !in_user && addr == W_HIGH) begin
                reach_q <= 1'b0;
                irq_q   <= 1'b0;
            end
            // a reached event wins over a clearing read in the same cycle
            if (counting && hit) begin
                reach_q <= 1'b1;
                if (!in_user) irq_q <= 1'b1;
            end
        end
    end

    // read data
    always_comb begin
        rdata = '0;
        unique case (addr)
            W_HIGH: rdata = in_user ? {reach_q, cnt_q[USER_W-1:LO_W]}
                                    : {1'b0, lim_q, {FRAC_W{1'b0}}};
            W_LOW:  rdata = in_user ? {cnt_q[LO_W-1:0], {FRAC_W{1'b0}}}
                                    : {reach_q, cnt_q[CNTR_W-1:0], {FRAC_W{1'b0}}};
            W_LIMIT_KEEP: rdata = '0;
            W_RUN:  rdata = {{(WORD_W-1){1'b0}}, run_q};
            default: rdata = '0;
        endcase
    end

    assign irq       = irq_q;
    assign user_mode = in_user;
    assign run       = run_q;

endmodule

// File: rtl/dual_mode_cpu_timer.sv
module dual_mode_cpu_timer
    import dmt_pkg::*;
#(
    parameter int NPROC = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    input  logic                    mode_wr,
    input  logic [NPROC-1:0]        mode_wdata,
    output logic [NPROC-1:0]        mode_rdata,
    input  logic [NPROC-1:0]        cpu_wr_en,
    input  logic [NPROC-1:0]        cpu_rd_en,
    input  logic [NPROC*ADDR_W-1:0] cpu_addr,
    input  logic [NPROC*WORD_W-1:0] cpu_wdata,
    output logic [NPROC*WORD_W-1:0] cpu_rdata,
    output logic [NPROC-1:0]        irq
);

    logic [NPROC-1:0] is_user;
    logic [NPROC-1:0] go_user;
    logic [NPROC-1:0] go_counter;
    logic [NPROC-1:0] run_vec;

    dmt_mode_bank #(.NPROC(NPROC)) u_mode (
        .mode_wr    (mode_wr),
        .mode_wdata (mode_wdata),
        .is_user    (is_user),
        .go_user    (go_user),
        .go_counter (go_counter),
        .mode_rdata (mode_rdata)
    );

    for (genvar gp = 0; gp < NPROC; gp++) begin : g_tmr
        dmt_timer_core u_core (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (tick),
            .go_user    (go_user[gp]),
            .go_counter (go_counter[gp]),
            .wr_en      (cpu_wr_en[gp]),
            .rd_en      (cpu_rd_en[gp]),
            .addr       (cpu_addr[gp*ADDR_W +: ADDR_W]),
            .wdata      (cpu_wdata[gp*WORD_W +: WORD_W]),
            .rdata      (cpu_rdata[gp*WORD_W +: WORD_W]),
            .irq        (irq[gp]),
            .user_mode  (is_user[gp]),
            .run        (run_vec[gp])
        );
    end

endmodule

// File: rtl/dmt_checker.sv
module dmt_checker #(
    parameter int NPROC = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             mode_wr,
    input logic [NPROC-1:0] mode_wdata,
    input logic [NPROC-1:0] mode_rdata,
    input logic [NPROC-1:0] irq,
    input logic [NPROC-1:0] run_vec
);

    // R2
    mode_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (mode_rdata == $past(mode_wdata)));

    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_wr |=> $stable(mode_rdata));

    for (genvar gi = 0; gi < NPROC; gi++) begin : g_chk
        // R9
        user_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
            mode_rdata[gi] |-> !irq[gi]);

        // R3
        irq_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[gi]) |-> $past(tick));

        // R11
        run_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_wr && !mode_wdata[gi] && mode_rdata[gi]) |=> run_vec[gi]);

        // R10
        enter_user_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_wr && mode_wdata[gi] && !mode_rdata[gi]) |=> !irq[gi]);
    end

endmodule

bind dual_mode_cpu_timer dmt_checker #(.NPROC(NPROC)) u_dmt_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .mode_wr    (mode_wr),
    .mode_wdata (mode_wdata),
    .mode_rdata (mode_rdata),
    .irq        (irq),
    .run_vec    (run_vec)
);

// File: tb/tb_dual_mode_cpu_timer.sv
`timescale 1ns/1ps
module tb_dual_mode_cpu_timer;

    localparam int NP = 4;
    localparam longint unsigned UMAX  = 64'h003F_FFFF_FFFF_FFFF;
    localparam longint unsigned CMASK = 64'h0000_0000_003F_FFFF;
    localparam longint unsigned LMASK = 64'h0000_0000_007F_FFFF;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick = 1'b0;
    logic             mode_wr = 1'b0;
    logic [NP-1:0]    mode_wdata = '0;
    logic [NP-1:0]    mode_rdata;
    logic [NP-1:0]    cpu_wr_en = '0;
    logic [NP-1:0]    cpu_rd_en = '0;
    logic [NP*2-1:0]  cpu_addr = '0;
    logic [NP*32-1:0] cpu_wdata = '0;
    logic [NP*32-1:0] cpu_rdata;
    logic [NP-1:0]    irq;

    int    tests = 0;
    int    fails = 0;
    int    cycles = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    dual_mode_cpu_timer #(.NPROC(NP)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata), .mode_rdata(mode_rdata),
        .cpu_wr_en(cpu_wr_en), .cpu_rd_en(cpu_rd_en), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq)
    );

    // behavioural reference model
    longint unsigned m_cnt [NP];
    longint unsigned m_lim [NP];
    bit              m_user[NP];
    bit              m_run [NP];
    bit              m_reach[NP];
    bit              m_irq [NP];

    function automatic bit [31:0] m_rd(int i, bit [1:0] a);
        longint unsigned c = m_cnt[i];
        longint unsigned l = m_lim[i];
        bit [31:0] v = 32'd0;
        if (m_user[i]) begin
            case (a)
                2'd0: v = {m_reach[i], c[53:23]};
                2'd1: v = {c[22:0], 9'd0};
                2'd3: v = {31'd0, m_run[i]};
                default: v = 32'd0;
            endcase
        end else begin
            case (a)
                2'd0: v = {1'b0, l[21:0], 9'd0};
                2'd1: v = {m_reach[i], c[21:0], 9'd0};
                2'd3: v = {31'd0, m_run[i]};
                default: v = 32'd0;
            endcase
        end
        return v;
    endfunction

    always @(posedge clk) begin
        for (int i = 0; i < NP; i++) begin : mdl
            bit [31:0] wd;
            bit [1:0]  a;
            bit        hit;
            longint unsigned n;
            wd  = cpu_wdata[i*32 +: 32];
            a   = cpu_addr[i*2 +: 2];
            hit = 1'b0;
            if (!rst_n) begin
                m_cnt[i] = 0; m_lim[i] = 0; m_user[i] = 0;
                m_run[i] = 1; m_reach[i] = 0; m_irq[i] = 0;
            end else if (mode_wr && (mode_wdata[i] != m_user[i])) begin
                if (mode_wdata[i]) begin
                    m_user[i] = 1; m_irq[i] = 0;
                end else begin
                    m_user[i] = 0; m_run[i] = 1; m_cnt[i] = m_cnt[i] & CMASK;
                end
            end else if (cpu_wr_en[i]) begin
                case (a)
                    2'd0: if (m_user[i]) begin
                              m_cnt[i] = (m_cnt[i] & LMASK) | (longint'(wd[30:0]) << 23);
                              m_reach[i] = 0;
                          end else begin
                              m_lim[i] = longint'(wd[30:9]); m_cnt[i] = 0; m_irq[i] = 0;
                          end
                    2'd1: if (m_user[i]) begin
                              m_cnt[i] = (m_cnt[i] & ~LMASK) | longint'(wd[31:9]);
                              m_reach[i] = 0;
                          end
                    2'd2: if (!m_user[i]) m_lim[i] = longint'(wd[30:9]);
                    default: m_run[i] = wd[0];
                endcase
            end else begin
                if (tick && (!m_user[i] || m_run[i])) begin
                    if (m_user[i]) begin
                        n = (m_cnt[i] + 1) & UMAX;
                        if (n == UMAX) begin m_cnt[i] = 0; hit = 1; end
                        else m_cnt[i] = n;
                    end else begin
                        n = (m_cnt[i] + 1) & CMASK;
                        if (m_lim[i] != 0 && n == m_lim[i]) begin m_cnt[i] = 0; hit = 1; end
                        else m_cnt[i] = n;
                    end
                end
                if (cpu_rd_en[i] && !m_user[i] && a == 2'd0) begin
                    m_reach[i] = 0; m_irq[i] = 0;
                end
                if (hit) begin
                    m_reach[i] = 1;
                    if (!m_user[i]) m_irq[i] = 1;
                end
            end
        end
    end

    task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NP; i++) begin
                chk({cur_req, " model rdata"}, 64'(cpu_rdata[i*32 +: 32]),
                    64'(m_rd(i, cpu_addr[i*2 +: 2])));
                chk({cur_req, " model irq"}, 64'(irq[i]), 64'(m_irq[i]));
                chk({cur_req, " model mode"}, 64'(mode_rdata[i]), 64'(m_user[i]));
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            fails++;
            $display("FAIL watchdog: got %0d cycles expected below 50000", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
        tick = 0; mode_wr = 0; cpu_wr_en = '0; cpu_rd_en = '0;
    endtask

    task automatic wr(int p, bit [1:0] a, bit [31:0] d);
        cpu_wr_en[p] = 1'b1;
        cpu_addr[p*2 +: 2] = a;
        cpu_wdata[p*32 +: 32] = d;
        step();
    endtask

    task automatic rd(int p, bit [1:0] a, output bit [31:0] v);
        cpu_rd_en[p] = 1'b1;
        cpu_addr[p*2 +: 2] = a;
        @(negedge clk);
        v = cpu_rdata[p*32 +: 32];
        step();
    endtask

    task automatic peek(int p, bit [1:0] a, output bit [31:0] v);
        cpu_addr[p*2 +: 2] = a;
        @(negedge clk);
        v = cpu_rdata[p*32 +: 32];
        step();
    endtask

    task automatic ticks(int n);
        for (int k = 0; k < n; k++) begin
            tick = 1'b1;
            step();
        end
    endtask

    task automatic set_mode(bit [NP-1:0] m);
        mode_wr = 1'b1;
        mode_wdata = m;
        step();
    endtask

    initial begin
        bit [31:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();

        cur_req = "R1";
        chk("R1 mode mask", 64'(mode_rdata), 64'd0);
        chk("R1 irq", 64'(irq), 64'd0);
        for (int p = 0; p < NP; p++) begin
            peek(p, 2'd3, v); chk("R1 run bit", 64'(v), 64'd1);
            peek(p, 2'd1, v); chk("R1 count", 64'(v), 64'd0);
            peek(p, 2'd0, v); chk("R1 limit", 64'(v), 64'd0);
        end

        cur_req = "R3";
        wr(1, 2'd0, 32'h600);
        ticks(2);
        peek(1, 2'd1, v); chk("R3 count", 64'(v), 64'h400);
        chk("R3 no irq yet", 64'(irq[1]), 64'd0);
        ticks(1);
        chk("R3 irq on limit", 64'(irq[1]), 64'd1);

        cur_req = "R4";
        rd(1, 2'd1, v); chk("R4 word1 reached", 64'(v), 64'h8000_0000);
        rd(1, 2'd0, v); chk("R4 word0 limit", 64'(v), 64'h600);
        chk("R4 irq cleared", 64'(irq[1]), 64'd0);
        peek(1, 2'd1, v); chk("R4 reached cleared", 64'(v), 64'd0);

        cur_req = "R5";
        ticks(1);
        wr(1, 2'd2, 32'hA00);
        ticks(3);
        chk("R5 keep count no irq", 64'(irq[1]), 64'd0);
        ticks(1);
        chk("R5 new limit hit", 64'(irq[1]), 64'd1);
        wr(1, 2'd0, 32'h600);
        chk("R5 limit write lowers irq", 64'(irq[1]), 64'd0);
        peek(1, 2'd1, v); chk("R5 count restarted", 64'(v), 64'h8000_0000);
        rd(1, 2'd0, v);

        cur_req = "R13";
        wr(1, 2'd1, 32'hFFFF_FE00);
        peek(1, 2'd1, v); chk("R13 counter word1 write ignored", 64'(v), 64'd0);

        cur_req = "R8";
        wr(1, 2'd3, 32'd0);
        ticks(2);
        peek(1, 2'd1, v); chk("R8 counter ignores run", 64'(v), 64'h400);
        peek(1, 2'd3, v); chk("R8 run readback", 64'(v), 64'd0);

        cur_req = "R10";
        wr(2, 2'd0, 32'h400);
        ticks(2);
        chk("R10 irq before switch", 64'(irq[2]), 64'd1);
        wr(2, 2'd3, 32'd0);
        set_mode(4'b0100);
        chk("R10 irq cleared", 64'(irq[2]), 64'd0);
        chk("R2 mask readback", 64'(mode_rdata), 64'h4);
        ticks(3);
        peek(2, 2'd1, v); chk("R10 halted stays", 64'(v), 64'd0);
        peek(2, 2'd0, v); chk("R6 user high word with reached", 64'(v), 64'h8000_0000);

        cur_req = "R8";
        wr(2, 2'd3, 32'd1);
        ticks(3);
        peek(2, 2'd1, v); chk("R8 user counting", 64'(v), 64'h600);

        cur_req = "R7";
        wr(2, 2'd0, 32'h1234_5678);
        peek(2, 2'd0, v); chk("R7 high load", 64'(v), 64'h1234_5678);
        peek(2, 2'd1, v); chk("R7 low kept", 64'(v), 64'h600);
        wr(2, 2'd1, 32'hABCD_E000);
        peek(2, 2'd1, v); chk("R7 low load", 64'(v), 64'hABCD_E000);
        peek(2, 2'd0, v); chk("R7 high kept", 64'(v), 64'h1234_5678);

        cur_req = "R9";
        wr(2, 2'd0, 32'h7FFF_FFFF);
        wr(2, 2'd1, 32'hFFFF_FA00);
        ticks(1);
        peek(2, 2'd1, v); chk("R9 near max low", 64'(v), 64'hFFFF_FC00);
        ticks(1);
        peek(2, 2'd0, v); chk("R9 wrap reached", 64'(v), 64'h8000_0000);
        peek(2, 2'd1, v); chk("R9 wrap zero", 64'(v), 64'd0);
        chk("R9 no user irq", 64'(irq[2]), 64'd0);
        rd(2, 2'd0, v);
        peek(2, 2'd0, v); chk("R6 user read no clear", 64'(v), 64'h8000_0000);
        wr(2, 2'd1, 32'd0);
        peek(2, 2'd0, v); chk("R7 write clears reached", 64'(v), 64'd0);

        cur_req = "R2";
        ticks(2);
        set_mode(4'b0110);
        peek(2, 2'd1, v); chk("R2 unchanged bit keeps count", 64'(v), 64'h400);
        peek(2, 2'd3, v); chk("R2 unchanged bit keeps run", 64'(v), 64'd1);
        chk("R2 mask readback", 64'(mode_rdata), 64'h6);

        cur_req = "R13";
        wr(2, 2'd2, 32'h7FFF_FE00);
        peek(2, 2'd1, v); chk("R13 user word2 ignored low", 64'(v), 64'h400);
        peek(2, 2'd0, v); chk("R13 user word2 ignored high", 64'(v), 64'd0);
        peek(2, 2'd2, v); chk("R13 word2 reads zero", 64'(v), 64'd0);

        cur_req = "R11";
        wr(2, 2'd3, 32'd0);
        set_mode(4'b0010);
        peek(2, 2'd3, v); chk("R11 run forced", 64'(v), 64'd1);
        peek(2, 2'd1, v); chk("R11 count kept", 64'(v), 64'h400);
        peek(2, 2'd0, v); chk("R11 limit kept", 64'(v), 64'h400);

        cur_req = "R12";
        mode_wr = 1'b1; mode_wdata = 4'b1010; tick = 1'b1;
        cpu_wr_en[3] = 1'b1; cpu_addr[6 +: 2] = 2'd0; cpu_wdata[96 +: 32] = 32'h1234_5000;
        step();
        peek(3, 2'd0, v); chk("R12 write dropped on switch", 64'(v), 64'd0);
        tick = 1'b1;
        cpu_wr_en[2] = 1'b1; cpu_addr[4 +: 2] = 2'd0; cpu_wdata[64 +: 32] = 32'h800;
        step();
        peek(2, 2'd1, v); chk("R12 write beats tick", 64'(v), 64'd0);
        ticks(3);
        tick = 1'b1;
        cpu_rd_en[2] = 1'b1; cpu_addr[4 +: 2] = 2'd0;
        step();
        chk("R12 reach beats clear", 64'(irq[2]), 64'd1);
        rd(2, 2'd0, v);
        chk("R4 irq cleared later", 64'(irq[2]), 64'd0);

        cur_req = "R3";
        ticks(20);
        chk("R3 free-run no irq", 64'(irq[0]), 64'd0);

        step();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule